// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it takes the accumulator value and one 8-bit operand. A 4-bit operation code picks one of fourteen functions. The block produces the result byte, a strobe saying whether the result belongs in the accumulator, and the flag byte that the operation would produce.

The flag register is the only state inside the block. It holds four bits: zero, subtract, half-carry and carry. On a clock edge where `op_en` is high, it loads the newly computed flags. The carry bit in this register feeds the carry-with and borrow-with operations. The subtract and half-carry bits steer the decimal adjust. Every operation has its own rule for each flag, so the next-flag logic is worked out separately for every operation code.

Instruction decode, operand fetch and memory access stay outside the block. The surrounding datapath presents `acc_in` and `opnd_in`. It writes `result` back into the accumulator when `result_we` is high.

Top module: `alu8_flags`

## Requirements
- R1: The flag byte on `flags_next` and `flags_q` is {Z, N, H, C, 0000}: Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 are always 0. While `rst_n` is low, `flags_q` is 0x00.
- R2: Codes 0 (add) and 1 (add with carry) produce acc_in + opnd_in, plus C for code 1. They set Z when the result byte is zero, clear N, set H from the carry out of bit 3 and set C from the carry out of bit 7. `result_we` is 1.
- R3: Codes 2 (subtract) and 3 (subtract with borrow) produce acc_in - opnd_in, minus C for code 3. They set Z when the result byte is zero, set N, set H from the borrow out of bit 3 and set C from the borrow out of bit 7. `result_we` is 1.
- R4: Code 7 (compare) sets the flags exactly as code 2 does. `result` carries the difference, but `result_we` is 0.
- R5: Code 4 (AND) produces acc_in & opnd_in. It sets Z from the result, sets H to 1 and clears N and C.
- R6: Code 5 (OR) and code 6 (XOR) set Z from the result and clear N, H and C.
- R7: Code 8 produces opnd_in + 1 and code 9 produces opnd_in - 1. Both set Z from the result. H is the carry out of bit 3 for code 8 and the borrow out of bit 3 for code 9. N is 0 for code 8 and 1 for code 9. C keeps its held value.
- R8: Code 11 produces ~acc_in and sets N and H to 1. Z and C keep their held values.
- R9: Code 12 sets C to 1 and code 13 inverts C. Both clear N and H and keep Z. `result` equals acc_in and `result_we` is 0.
- R10: Code 10 (decimal adjust) works from the held N flag.
  - With N=0, it adds 0x60 when C=1 or acc_in > 0x99, and in that case sets C. It adds 0x06 when H=1 or acc_in[3:0] > 9.
  - With N=1, it subtracts 0x60 when C=1 and subtracts 0x06 when H=1. C is kept.
  - In both directions it sets Z from the result, clears H and keeps N.
- R11: The flag register loads the `flags_next` byte on a rising clock edge only when `op_en` is 1. Otherwise it holds its value.
- R12: Codes 14 and 15 do nothing: `result` equals acc_in, `result_we` is 0, and `flags_next` equals `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_en | input | 1 | Commit the computed flags at the next rising edge |
| op | input | 4 | Operation code, 0..15 |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand; the source for increment and decrement |
| result | output | 8 | Result byte |
| result_we | output | 1 | High when the result is to be written to the accumulator |
| flags_next | output | 8 | Flag byte this operation produces |
| flags_q | output | 8 | Held flag byte |

## Verification
`result`, `result_we` and `flags_next` depend only on the inputs and the held flags, so they are valid in the same cycle the inputs change. `flags_q` changes one rising edge later, and only when `op_en` was high at that edge.

The bench drives each input set at a falling edge and samples the combinational outputs 1 ns later. It reads `flags_q` at the following falling edge.

The exhaustive sweeps keep `op_en` low so the held flags cannot move. This lets the bench apply many input sets inside one clock period and compare each one a fraction of a nanosecond after it was applied.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_en,
  input  logic [3:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  output logic [7:0] result,
  output logic       result_we,
  output logic [7:0] flags_next,
  output logic [7:0] flags_q
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CP  = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_DAA = 4'd10, OP_CPL = 4'd11;
  localparam logic [3:0] OP_SCF = 4'd12, OP_CCF = 4'd13;

  // held flags: [3]=Z [2]=N [1]=H [0]=C
  logic [3:0] fl_q, fl_d;
  logic       fz, fn, fh, fc;
  assign {fz, fn, fh, fc} = fl_q;

  logic       cin;
  logic [8:0] add_w, sub_w;
  logic [4:0] add_lo, sub_lo;
  assign cin    = (op == OP_ADC || op == OP_SBC) ? fc : 1'b0;
  assign add_w  = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin};
  assign add_lo = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin};
  assign sub_w  = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cin};
  assign sub_lo = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cin};

  logic [7:0] daa_adj, daa_res;
  logic       daa_c;
  always_comb begin
    daa_adj = 8'h00;
    daa_c   = fc;
    if (!fn) begin
      if (fc || acc_in > 8'h99) begin
        daa_adj = daa_adj | 8'h60;
        daa_c   = 1'b1;
      end
      if (fh || acc_in[3:0] > 4'd9) daa_adj = daa_adj | 8'h06;
      daa_res = acc_in + daa_adj;
    end else begin
      if (fc) daa_adj = daa_adj | 8'h60;
      if (fh) daa_adj = daa_adj | 8'h06;
      daa_res = acc_in - daa_adj;
    end
  end

  always_comb begin
    result    = acc_in;
    result_we = 1'b0;
    fl_d      = fl_q;
    case (op)
      OP_ADD, OP_ADC: begin
        result = add_w[7:0]; result_we = 1'b1;
        fl_d = {add_w[7:0] == 8'h00, 1'b0, add_lo[4], add_w[8]};
      end
      OP_SUB, OP_SBC, OP_CP: begin
        result = sub_w[7:0]; result_we = (op != OP_CP);
        fl_d = {sub_w[7:0] == 8'h00, 1'b1, sub_lo[4], sub_w[8]};
      end
      OP_AND: begin
        result = acc_in & opnd_in; result_we = 1'b1;
        fl_d = {(acc_in & opnd_in) == 8'h00, 1'b0, 1'b1, 1'b0};
      end
      OP_OR: begin
        result = acc_in | opnd_in; result_we = 1'b1;
        fl_d = {(acc_in | opnd_in) == 8'h00, 3'b000};
      end
      OP_XOR: begin
        result = acc_in ^ opnd_in; result_we = 1'b1;
        fl_d = {(acc_in ^ opnd_in) == 8'h00, 3'b000};
      end
      OP_INC: begin
        result = opnd_in + 8'd1; result_we = 1'b1;
        fl_d = {opnd_in == 8'hFF, 1'b0, opnd_in[3:0] == 4'hF, fc};
      end
      OP_DEC: begin
        result = opnd_in - 8'd1; result_we = 1'b1;
        fl_d = {opnd_in == 8'h01, 1'b1, opnd_in[3:0] == 4'h0, fc};
      end
      OP_DAA: begin
        result = daa_res; result_we = 1'b1;
        fl_d = {daa_res == 8'h00, fn, 1'b0, daa_c};
      end
      OP_CPL: begin
        result = ~acc_in; result_we = 1'b1;
        fl_d = {fz, 1'b1, 1'b1, fc};
      end
      OP_SCF: fl_d = {fz, 1'b0, 1'b0, 1'b1};
      OP_CCF: fl_d = {fz, 1'b0, 1'b0, ~fc};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     fl_q <= 4'b0000;
    else if (op_en) fl_q <= fl_d;

  assign flags_next = {fl_d, 4'b0000};
  assign flags_q    = {fl_q, 4'b0000};

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(flags_q)); // R11
  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && (op == OP_INC || op == OP_DEC) |=> flags_q[4] == $past(flags_q[4])); // R7
  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == OP_AND |=> flags_q[5] && !flags_q[6] && !flags_q[4]); // R5
  AST_SCF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == OP_SCF |=> flags_q[4] && !flags_q[5] && !flags_q[6]); // R9
  AST_CPL_KEEPS_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == OP_CPL |=> flags_q[6] && flags_q[5] && flags_q[7] == $past(flags_q[7]) && flags_q[4] == $past(flags_q[4])); // R8
  AST_DAA_KEEPS_N: assert property (@(posedge clk) disable iff (!rst_n)
    op_en && op == OP_DAA |=> !flags_q[5] && flags_q[6] == $past(flags_q[6])); // R10
  AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CP |-> !result_we); // R4
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [3:0] op = 4'd14;
  logic [7:0] acc_in = 8'h00, opnd_in = 8'h00;
  logic [7:0] result, flags_next, flags_q;
  logic       result_we;
  int         checks = 0, errors = 0;
  logic [3:0] mf = 4'b0000;

  always #4 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .result(result), .result_we(result_we), .flags_next(flags_next), .flags_q(flags_q)
  );

  // {we, op, a, b, result, ZNHC} applied in order from reset flags 0000
  localparam logic [32:0] VEC [0:20] = '{
    {1'b1, 4'd0,  8'h3A, 8'hC6, 8'h00, 4'b1011},
    {1'b1, 4'd1,  8'h01, 8'h01, 8'h03, 4'b0000},
    {1'b1, 4'd2,  8'h3E, 8'h3E, 8'h00, 4'b1100},
    {1'b1, 4'd2,  8'h3E, 8'h40, 8'hFE, 4'b0101},
    {1'b1, 4'd3,  8'h3B, 8'h2A, 8'h10, 4'b0100},
    {1'b0, 4'd7,  8'h3C, 8'h2F, 8'h0D, 4'b0110},
    {1'b1, 4'd4,  8'h5A, 8'h3F, 8'h1A, 4'b0010},
    {1'b1, 4'd5,  8'h00, 8'h00, 8'h00, 4'b1000},
    {1'b1, 4'd6,  8'hFF, 8'hFF, 8'h00, 4'b1000},
    {1'b0, 4'd12, 8'h00, 8'h00, 8'h00, 4'b1001},
    {1'b1, 4'd8,  8'h00, 8'h0F, 8'h10, 4'b0011},
    {1'b1, 4'd9,  8'h00, 8'h01, 8'h00, 4'b1101},
    {1'b0, 4'd13, 8'h00, 8'h00, 8'h00, 4'b1000},
    {1'b1, 4'd0,  8'h45, 8'h38, 8'h7D, 4'b0000},
    {1'b1, 4'd10, 8'h7D, 8'h00, 8'h83, 4'b0000},
    {1'b1, 4'd2,  8'h83, 8'h38, 8'h4B, 4'b0110},
    {1'b1, 4'd10, 8'h4B, 8'h00, 8'h45, 4'b0100},
    {1'b1, 4'd11, 8'h35, 8'h00, 8'hCA, 4'b0110},
    {1'b0, 4'd14, 8'h12, 8'h00, 8'h12, 4'b0110},
    {1'b1, 4'd0,  8'h99, 8'h99, 8'h32, 4'b0011},
    {1'b1, 4'd10, 8'h32, 8'h00, 8'h98, 4'b0001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd7:       return "R4";
      4'd4:       return "R5";
      4'd5, 4'd6: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10:      return "R10";
      4'd11:      return "R8";
      4'd12, 4'd13: return "R9";
      default:    return "R12";
    endcase
  endfunction

  // returns {we, result, Z, N, H, C}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic [3:0] f);
    int ia, ib, ci, r;
    logic [7:0] res;
    logic z, n, h, c, we;
    ia = int'(a); ib = int'(b);
    {z, n, h, c} = f;
    res = a; we = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        ci = (o == 4'd1 && c) ? 1 : 0;
        r = ia + ib + ci; res = r[7:0]; we = 1'b1;
        z = (res == 0); n = 1'b0; h = ((ia % 16) + (ib % 16) + ci) > 15; c = r > 255;
      end
      4'd2, 4'd3, 4'd7: begin
        ci = (o == 4'd3 && c) ? 1 : 0;
        r = ia - ib - ci; res = r[7:0]; we = (o != 4'd7);
        z = (res == 0); n = 1'b1; h = (ia % 16) < ((ib % 16) + ci); c = ia < ib + ci;
      end
      4'd4: begin res = a & b; we = 1'b1; z = (res == 0); n = 0; h = 1; c = 0; end
      4'd5: begin res = a | b; we = 1'b1; z = (res == 0); n = 0; h = 0; c = 0; end
      4'd6: begin res = a ^ b; we = 1'b1; z = (res == 0); n = 0; h = 0; c = 0; end
      4'd8: begin r = ib + 1; res = r[7:0]; we = 1'b1; z = (res == 0); n = 0; h = (ib % 16) == 15; end
      4'd9: begin r = ib + 255; res = r[7:0]; we = 1'b1; z = (res == 0); n = 1; h = (ib % 16) == 0; end
      4'd10: begin
        r = ia;
        if (!n) begin
          if (c || ia > 153) begin r = r + 96; c = 1'b1; end
          if (h || (ia % 16) > 9) r = r + 6;
        end else begin
          if (c) r = r - 96;
          if (h) r = r - 6;
        end
        res = r[7:0]; we = 1'b1; z = (res == 0); h = 1'b0;
      end
      4'd11: begin res = ~a; we = 1'b1; n = 1; h = 1; end
      4'd12: begin n = 0; h = 0; c = 1; end
      4'd13: begin n = 0; h = 0; c = ~c; end
      default: ;
    endcase
    return {we, res, z, n, h, c};
  endfunction

  task automatic do_op(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b);
    logic [12:0] e;
    @(negedge clk);
    op_en = 1'b1; op = o; acc_in = a; opnd_in = b;
    #1;
    e = model(o, a, b, mf);
    check({result_we, result, flags_next} == {e[12:4], e[3:0], 4'b0000}, req_of(o),
          {15'd0, result_we, result, flags_next}, {15'd0, e[12:4], e[3:0], 4'b0000});
    @(negedge clk);
    op_en = 1'b0; op = 4'd14;
    mf = e[3:0];
    check(flags_q == {mf, 4'b0000}, "R11", {24'd0, flags_q}, {24'd0, mf, 4'b0000});
  endtask

  task automatic sweep_state;
    logic [12:0] e;
    for (int o = 0; o < 16; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          if (o >= 8 && b > 0 && o != 8 && o != 9) break;
          if ((o == 8 || o == 9) && a > 0) break;
          op = 4'(o); acc_in = 8'(a); opnd_in = 8'(b);
          #0.1;
          e = model(4'(o), 8'(a), 8'(b), mf);
          if ({result_we, result, flags_next} != {e[12:4], e[3:0], 4'b0000})
            check(1'b0, req_of(4'(o)), {15'd0, result_we, result, flags_next}, {15'd0, e[12:4], e[3:0], 4'b0000});
          else
            checks++;
        end
      end
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(flags_q == 8'h00, "R1", {24'd0, flags_q}, 32'h0);
    rst_n = 1'b1;

    // directed table, expected values written by hand
    for (int i = 0; i < 21; i++) begin
      logic [32:0] v;
      v = VEC[i];
      @(negedge clk);
      op_en = 1'b1; op = v[31:28]; acc_in = v[27:20]; opnd_in = v[19:12];
      #1;
      check({result_we, result, flags_next} == {v[32], v[11:4], v[3:0], 4'b0000}, req_of(v[31:28]),
            {15'd0, result_we, result, flags_next}, {15'd0, v[32], v[11:4], v[3:0], 4'b0000});
      @(negedge clk);
      op_en = 1'b0; op = 4'd14;
      mf = v[3:0];
      check(flags_q == {mf, 4'b0000}, "R11", {24'd0, flags_q}, {24'd0, mf, 4'b0000});
    end

    // R11: op_en low, a carry-flipping code must not reach the register
    do_op(4'd12, 8'h00, 8'h00);
    @(negedge clk); op = 4'd13;
    @(negedge clk);
    check(flags_q == {mf, 4'b0000}, "R11", {24'd0, flags_q}, {24'd0, mf, 4'b0000});
    op = 4'd14;

    // R12: no-op codes commit with op_en high and still change nothing
    do_op(4'd15, 8'hA5, 8'h5A);
    check(result_we == 1'b0 && flags_q == 8'h10, "R12", {24'd0, flags_q}, 32'h10);

    // R1: reset mid-run clears the register
    do_op(4'd2, 8'h00, 8'h01);
    @(negedge clk); rst_n = 1'b0; #1;
    check(flags_q == 8'h00, "R1", {24'd0, flags_q}, 32'h0);
    mf = 4'b0000;
    @(negedge clk); rst_n = 1'b1;

    // exhaustive comparison against the model in seven held-flag states
    do_op(4'd5, 8'h00, 8'h00); sweep_state();
    do_op(4'd12, 8'h00, 8'h00); sweep_state();
    do_op(4'd0, 8'h0F, 8'h01); sweep_state();
    do_op(4'd0, 8'hFF, 8'h01); sweep_state();
    do_op(4'd2, 8'h00, 8'h00); sweep_state();
    do_op(4'd2, 8'h00, 8'h01); sweep_state();
    do_op(4'd2, 8'h10, 8'h01); sweep_state();

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule